// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns the operation field and the function field of a fetched 32-bit instruction into the control lines of a single-cycle processor datapath. It has no state: every output follows its inputs within the same cycle. The operation field is bits 31..26 of the instruction and the function field is bits 5..0. The datapath wires them straight from the instruction register into this block. The outputs choose the register-file destination, the second ALU operand, the write-back source and the memory strobes. They also flag branch and jump instructions, and give a two-bit ALU class and a four-bit ALU function code.

Decoding happens in two levels. A per-opcode table sets the datapath controls and a coarse ALU class. A second table uses that class, together with the low four bits of the function field, to pick the exact ALU function. An operation field that the table does not know raises the illegal flag. A register-format instruction whose function nibble is not one of the five supported values also raises it. Whenever the flag is high, every write, read strobe and control-flow strobe is held low, so an undecodable instruction cannot change architectural state.

Top module: `instr_ctrl_decoder`

## Requirements
- R1: Operation field 000000 with a supported function nibble drives dst_from_rd=1, rf_we=1, alu_class=10, illegal=0, and operand_imm, wb_from_mem, dm_re, dm_we, is_branch and is_jump all 0.
- R2: Operation field 100011 (load) drives operand_imm=1, wb_from_mem=1, rf_we=1, dm_re=1, alu_class=00, alu_fn=0010, illegal=0, and every other control 0.
- R3: Operation field 101011 (store) drives operand_imm=1, dm_we=1, alu_class=00, alu_fn=0010, illegal=0, and every other control 0 (the unused selects included).
- R4: Operation field 000100 (branch on equal) drives is_branch=1, alu_class=01, alu_fn=0110, illegal=0, and every other control 0.
- R5: Operation field 000010 (jump) drives is_jump=1, alu_class=00, alu_fn=0010, illegal=0, and every other control 0.
- R6: For operation field 000000 the alu_fn code comes from function bits 3..0 as follows: 0000 gives 0010 (add), 0010 gives 0110 (subtract), 0100 gives 0000 (and), 0101 gives 0001 (or), 1010 gives 0111 (set-less-than). Function bits 5..4 have no effect on any output.
- R7: Operation field 000000 with any other function nibble drives illegal=1, rf_we=0, dm_we=0, dm_re=0, is_branch=0, is_jump=0, alu_fn=0010, and keeps dst_from_rd=1 and alu_class=10.
- R8: Any operation field other than the five above drives illegal=1, alu_fn=0010 and every other output 0.
- R9: No input combination asserts more than one of rf_we, dm_we, is_branch and is_jump at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_opcode | input | 6 | Operation field, instruction bits 31..26 |
| i_funct | input | 6 | Function field, instruction bits 5..0 |
| o_dst_from_rd | output | 1 | 1: write register index from bits 15..11, 0: from bits 20..16 |
| o_operand_imm | output | 1 | 1: ALU second operand is the sign-extended immediate |
| o_wb_from_mem | output | 1 | 1: write-back data comes from data memory |
| o_rf_we | output | 1 | Register-file write enable |
| o_dm_re | output | 1 | Data-memory read strobe |
| o_dm_we | output | 1 | Data-memory write strobe |
| o_is_branch | output | 1 | Conditional branch on equal operands |
| o_is_jump | output | 1 | Unconditional jump |
| o_alu_class | output | 2 | Coarse ALU class: 00 address add, 01 compare, 10 register format |
| o_alu_fn | output | 4 | ALU function code |
| o_illegal | output | 1 | Instruction not supported; all writes suppressed |

## Verification
Every one of the 4096 pairs of operation and function field is applied, and each full output vector is compared with one built from the tables in the requirements. The five known operation fields combined with every function value show that only the register format listens to the function field. All 64 function values under operation 000000 separate the five supported nibbles from the eleven unsupported ones. They also show that bits 5..4 are ignored. The 59 unknown operation fields check that the illegal path forces every output to its safe value.

// File: rtl/instr_ctrl_pkg.sv
package instr_ctrl_pkg;

  localparam int OPC_W    = 6;
  localparam int FUNCT_W  = 6;
  localparam int FN_KEY_W = 4;
  localparam int ALU_FN_W = 4;
  localparam int N_RFN    = 5;

  typedef enum logic [1:0] {
    CLS_ADDR = 2'b00,
    CLS_CMP  = 2'b01,
    CLS_REG  = 2'b10
  } alu_class_e;

  typedef struct packed {
    logic       dst_rd;
    logic       imm;
    logic       wb_mem;
    logic       rf_we;
    logic       dm_re;
    logic       dm_we;
    logic       br;
    logic       jmp;
    alu_class_e cls;
  } ctl_t;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JMP   = 6'b000010;

  localparam logic [ALU_FN_W-1:0] FN_ADD = 4'b0010;
  localparam logic [ALU_FN_W-1:0] FN_SUB = 4'b0110;
  localparam logic [ALU_FN_W-1:0] FN_AND = 4'b0000;
  localparam logic [ALU_FN_W-1:0] FN_OR  = 4'b0001;
  localparam logic [ALU_FN_W-1:0] FN_SLT = 4'b0111;

  localparam logic [FN_KEY_W-1:0] RFN_KEY [N_RFN] = '{4'b0000, 4'b0010, 4'b0100, 4'b0101, 4'b1010};
  localparam logic [ALU_FN_W-1:0] RFN_VAL [N_RFN] = '{FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT};

  localparam ctl_t CTL_NONE = '{dst_rd: 1'b0, imm: 1'b0, wb_mem: 1'b0, rf_we: 1'b0,
                                dm_re: 1'b0, dm_we: 1'b0, br: 1'b0, jmp: 1'b0, cls: CLS_ADDR};

endpackage

// File: rtl/instr_opc_table.sv
module instr_opc_table
  import instr_ctrl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output ctl_t             ctl,
  output logic             known
);

  always_comb begin
    ctl   = CTL_NONE;
    known = 1'b1;
    unique case (opcode)
      OPC_REG: begin
        ctl.dst_rd = 1'b1;
        ctl.rf_we  = 1'b1;
        ctl.cls    = CLS_REG;
      end
      OPC_LOAD: begin
        ctl.imm    = 1'b1;
        ctl.wb_mem = 1'b1;
        ctl.rf_we  = 1'b1;
        ctl.dm_re  = 1'b1;
      end
      OPC_STORE: begin
        ctl.imm   = 1'b1;
        ctl.dm_we = 1'b1;
      end
      OPC_BEQ: begin
        ctl.br  = 1'b1;
        ctl.cls = CLS_CMP;
      end
      OPC_JMP: begin
        ctl.jmp = 1'b1;
      end
      default: begin
        known = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/instr_fn_table.sv
module instr_fn_table
  import instr_ctrl_pkg::*;
#(
  parameter int KEY_W = FN_KEY_W,
  parameter int OUT_W = ALU_FN_W,
  parameter int N_KEY = N_RFN
) (
  input  alu_class_e       cls,
  input  logic [KEY_W-1:0] fn_key,
  output logic [OUT_W-1:0] alu_fn,
  output logic             fn_ok
);

  logic [N_KEY-1:0] hit;
  logic [OUT_W-1:0] reg_fn;

  for (genvar g = 0; g < N_KEY; g++) begin : g_key
    assign hit[g] = (fn_key == RFN_KEY[g]);
  end

  always_comb begin
    reg_fn = FN_ADD;
    for (int k = 0; k < N_KEY; k++) begin
      if (hit[k]) reg_fn = RFN_VAL[k];
    end
  end

  always_comb begin
    fn_ok  = 1'b1;
    alu_fn = FN_ADD;
    if (cls[0]) begin
      alu_fn = FN_SUB;
    end else if (cls[1]) begin
      alu_fn = reg_fn;
      fn_ok  = |hit;
    end
  end

endmodule

// File: rtl/instr_write_gate.sv
module instr_write_gate
  import instr_ctrl_pkg::*;
(
  input  ctl_t ctl_in,
  input  logic block,
  output ctl_t ctl_out
);

  always_comb begin
    ctl_out = ctl_in;
    if (block) begin
      ctl_out.rf_we = 1'b0;
      ctl_out.dm_re = 1'b0;
      ctl_out.dm_we = 1'b0;
      ctl_out.br    = 1'b0;
      ctl_out.jmp   = 1'b0;
    end
  end

endmodule

// File: rtl/instr_ctrl_decoder.sv
module instr_ctrl_decoder
  import instr_ctrl_pkg::*;
(
  input  logic [5:0] i_opcode,
  input  logic [5:0] i_funct,
  output logic       o_dst_from_rd,
  output logic       o_operand_imm,
  output logic       o_wb_from_mem,
  output logic       o_rf_we,
  output logic       o_dm_re,
  output logic       o_dm_we,
  output logic       o_is_branch,
  output logic       o_is_jump,
  output logic [1:0] o_alu_class,
  output logic [3:0] o_alu_fn,
  output logic       o_illegal
);

  ctl_t                  raw_ctl;
  ctl_t                  safe_ctl;
  logic                  opc_known;
  logic                  fn_ok;
  logic [ALU_FN_W-1:0]   fn_code;
  logic                  illegal;
  logic [FUNCT_W-FN_KEY_W-1:0] funct_hi_unused;

  assign funct_hi_unused = i_funct[FUNCT_W-1:FN_KEY_W];

  instr_opc_table u_opc (
    .opcode (i_opcode),
    .ctl    (raw_ctl),
    .known  (opc_known)
  );

  instr_fn_table #(
    .KEY_W (FN_KEY_W),
    .OUT_W (ALU_FN_W),
    .N_KEY (N_RFN)
  ) u_fn (
    .cls    (raw_ctl.cls),
    .fn_key (i_funct[FN_KEY_W-1:0]),
    .alu_fn (fn_code),
    .fn_ok  (fn_ok)
  );

  assign illegal = ~opc_known | ~fn_ok;

  instr_write_gate u_gate (
    .ctl_in  (raw_ctl),
    .block   (illegal),
    .ctl_out (safe_ctl)
  );

  assign o_dst_from_rd = safe_ctl.dst_rd;
  assign o_operand_imm = safe_ctl.imm;
  assign o_wb_from_mem = safe_ctl.wb_mem;
  assign o_rf_we       = safe_ctl.rf_we;
  assign o_dm_re       = safe_ctl.dm_re;
  assign o_dm_we       = safe_ctl.dm_we;
  assign o_is_branch   = safe_ctl.br;
  assign o_is_jump     = safe_ctl.jmp;
  assign o_alu_class   = safe_ctl.cls;
  assign o_alu_fn      = fn_code;
  assign o_illegal     = illegal;

endmodule

// File: rtl/instr_ctrl_decoder_chk.sv
module instr_ctrl_decoder_chk (
  input logic [5:0] i_opcode,
  input logic       o_dst_from_rd,
  input logic       o_wb_from_mem,
  input logic       o_rf_we,
  input logic       o_dm_re,
  input logic       o_dm_we,
  input logic       o_is_branch,
  input logic       o_is_jump,
  input logic [1:0] o_alu_class,
  input logic [3:0] o_alu_fn,
  input logic       o_illegal
);

  always_comb begin
    // R7 / R8: an undecodable instruction never writes or redirects
    assert_illegal_quiet_R8: assert (!o_illegal || !(o_rf_we | o_dm_we | o_dm_re | o_is_branch | o_is_jump));
    // R2: a memory read always returns its data to the register file
    assert_load_writeback_R2: assert (!o_dm_re || (o_rf_we && o_wb_from_mem && !o_dst_from_rd));
    // R4: the compare class always subtracts
    assert_cmp_sub_R4: assert (o_alu_class != 2'b01 || o_alu_fn == 4'b0110);
    // R5: the address class always adds
    assert_addr_add_R5: assert (o_alu_class != 2'b00 || o_alu_fn == 4'b0010);
    // R9: at most one side effect per instruction
    assert_single_effect_R9: assert ($onehot0({o_rf_we, o_dm_we, o_is_branch, o_is_jump}));
    // R1: register-format instructions keep the register class
    assert_reg_class_R1: assert (i_opcode != 6'b000000 || o_alu_class == 2'b10);
  end

endmodule

bind instr_ctrl_decoder instr_ctrl_decoder_chk u_chk (
  .i_opcode      (i_opcode),
  .o_dst_from_rd (o_dst_from_rd),
  .o_wb_from_mem (o_wb_from_mem),
  .o_rf_we       (o_rf_we),
  .o_dm_re       (o_dm_re),
  .o_dm_we       (o_dm_we),
  .o_is_branch   (o_is_branch),
  .o_is_jump     (o_is_jump),
  .o_alu_class   (o_alu_class),
  .o_alu_fn      (o_alu_fn),
  .o_illegal     (o_illegal)
);

// File: tb/instr_ctrl_decoder_test.sv
module instr_ctrl_decoder_test;

  logic       clk = 1'b0;
  logic [5:0] opc;
  logic [5:0] fn;
  logic       dst, imm, wbm, rfwe, dmre, dmwe, br, jmp, ill;
  logic [1:0] cls;
  logic [3:0] afn;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  instr_ctrl_decoder uut (
    .i_opcode      (opc),
    .i_funct       (fn),
    .o_dst_from_rd (dst),
    .o_operand_imm (imm),
    .o_wb_from_mem (wbm),
    .o_rf_we       (rfwe),
    .o_dm_re       (dmre),
    .o_dm_we       (dmwe),
    .o_is_branch   (br),
    .o_is_jump     (jmp),
    .o_alu_class   (cls),
    .o_alu_fn      (afn),
    .o_illegal     (ill)
  );

  // vector order: dst imm wbm rfwe dmre dmwe br jmp cls[1:0] fn[3:0] illegal
  function automatic logic [14:0] model(input logic [5:0] o, input logic [5:0] f);
    logic [3:0] rf;
    logic       ok;
    ok = 1'b1;
    case (f[3:0])
      4'b0000: rf = 4'b0010;
      4'b0010: rf = 4'b0110;
      4'b0100: rf = 4'b0000;
      4'b0101: rf = 4'b0001;
      4'b1010: rf = 4'b0111;
      default: begin rf = 4'b0010; ok = 1'b0; end
    endcase
    case (o)
      6'd0:    model = ok ? {8'b1001_0000, 2'b10, rf, 1'b0}
                          : {8'b1000_0000, 2'b10, 4'b0010, 1'b1};
      6'd35:   model = {8'b0111_1000, 2'b00, 4'b0010, 1'b0};
      6'd43:   model = {8'b0100_0100, 2'b00, 4'b0010, 1'b0};
      6'd4:    model = {8'b0000_0010, 2'b01, 4'b0110, 1'b0};
      6'd2:    model = {8'b0000_0001, 2'b00, 4'b0010, 1'b0};
      default: model = {8'b0000_0000, 2'b00, 4'b0010, 1'b1};
    endcase
  endfunction

  function automatic string tag(input logic [5:0] o, input logic [5:0] f);
    case (o)
      6'd0: begin
        case (f[3:0])
          4'b0000, 4'b0010, 4'b0100, 4'b0101, 4'b1010: tag = "R1/R6";
          default: tag = "R7";
        endcase
      end
      6'd35:   tag = "R2";
      6'd43:   tag = "R3";
      6'd4:    tag = "R4";
      6'd2:    tag = "R5";
      default: tag = "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [14:0] got, input logic [14:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s opc=%b fn=%b got=%b exp=%b", req, opc, fn, got, exp);
    end
  endtask

  initial begin
    opc = 6'd0;
    fn  = 6'd0;
    @(negedge clk);
    // initial pattern: register-format add (R1, R6)
    check("R1", {dst, imm, wbm, rfwe, dmre, dmwe, br, jmp, cls, afn, ill}, model(6'd0, 6'd0));
    for (int o = 0; o < 64; o++) begin
      for (int f = 0; f < 64; f++) begin
        @(posedge clk);
        opc = 6'(o);
        fn  = 6'(f);
        @(negedge clk);
        check(tag(opc, fn), {dst, imm, wbm, rfwe, dmre, dmwe, br, jmp, cls, afn, ill}, model(opc, fn));
        // R9: never more than one side effect
        total++;
        if ($countones({rfwe, dmwe, br, jmp}) > 1) begin
          bad++;
          $display("FAIL R9 opc=%b fn=%b got=%b exp=onehot0", opc, fn, {rfwe, dmwe, br, jmp});
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=running exp=finished");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule